// File: doc/BRIEF.md
# Floating-Point Control and Status Register

This block holds the 32-bit control and status word of a floating-point unit. Software reads and writes the whole word through a plain write port and a continuous read port. The arithmetic unit has its own update port. Through it, the unit can:

- overwrite the six-bit field of exception causes from the last operation;
- OR new sticky exception flags into the accumulated flags field;
- set or clear one of eight compare condition codes.

The eight condition codes are not contiguous in the word. Code 0 sits on its own below the other seven. A separate output splices them into one packed byte, so branch logic can index them directly. A combinational trap output rises whenever a recorded cause is also enabled, or when the unimplemented-operation cause is present. That cause cannot be masked. Rounding control, pipeline trapping and the datapath itself live elsewhere.

Top module: `fcsr_reg`

## Requirements
- R1: Synchronous reset clears all 32 bits. After reset the read port, the packed condition byte and trap are all zero.
- R2: A software write stores all 32 bits of `sw_wdata`. The new value appears on `sw_rdata` after the next rising clock edge.
- R3: A cause update replaces bits 17:12 with `au_cause` and leaves every other bit unchanged. The cause field keeps its value in any cycle without a cause update or a software write.
- R4: A flag update ORs `au_flags` into bits 6:2. It never clears a flag that is already set, and an update of all zeros leaves the field unchanged.
- R5: A condition-code update writes `au_cc_val` into a single bit and touches no other bit. Code 0 is bit 23. Code n, for n from 1 to 7, is bit n+24.
- R6: `cc_byte` bit 0 equals word bit 23. `cc_byte` bits 7:1 equal word bits 31:25.
- R7: The exception bits are ordered inexact, underflow, overflow, divide-by-zero, invalid, unimplemented, from the lowest cause bit up. The enable field occupies bits 11:7 and holds the five maskable exceptions in the same order. `trap` is high exactly when (cause bits 16:12 AND enable bits 11:7) is nonzero, or when cause bit 17 (unimplemented) is set.
- R8: If a software write and any arithmetic-unit update fall in the same cycle, the stored word equals `sw_wdata` and all arithmetic-unit updates are dropped.
- R9: Cause, flag and condition-code updates in the same cycle, without a software write, all take effect together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write value |
| sw_rdata | output | 32 | Current register word |
| au_cause_we | input | 1 | Replace the cause field |
| au_cause | input | 6 | New cause bits |
| au_flag_we | input | 1 | Merge sticky flags |
| au_flags | input | 5 | Flags to OR in |
| au_cc_we | input | 1 | Condition-code update strobe |
| au_cc_sel | input | 3 | Condition code to update |
| au_cc_val | input | 1 | Value written to the selected code |
| cc_byte | output | 8 | Packed condition codes, code n in bit n |
| trap | output | 1 | An enabled or unmaskable cause is present |

## Verification
The assertions assume the write strobes are never unknown while reset is low. They also assume that each strobe's data is meaningful only in the cycle the strobe is high. The stimulus drives every input on the falling edge, with explicit zeros when a strobe is idle, so the strobes are never left floating. The sequences cover single-field updates, a software write colliding with all three arithmetic updates, and all three arithmetic updates landing together. Causes are chosen on both sides of the enable mask, so trap is seen both masked and unmasked.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
    localparam int WORD_W    = 32;
    localparam int CC_COUNT  = 8;
    localparam int CC_SEL_W  = $clog2(CC_COUNT);
    localparam int CC0_POS   = 23;
    localparam int CCHI_LSB  = 25;
    localparam int CCHI_MSB  = CCHI_LSB + CC_COUNT - 2;
    localparam int CAUSE_W   = 6;
    localparam int CAUSE_LSB = 12;
    localparam int CAUSE_MSB = CAUSE_LSB + CAUSE_W - 1;
    localparam int MASK_W    = 5;
    localparam int EN_LSB    = 7;
    localparam int EN_MSB    = EN_LSB + MASK_W - 1;
    localparam int FLAG_LSB  = 2;
    localparam int FLAG_MSB  = FLAG_LSB + MASK_W - 1;

    typedef enum logic [CAUSE_W-1:0] {
        EXC_INEXACT = 6'd1,
        EXC_UNDER   = 6'd2,
        EXC_OVER    = 6'd4,
        EXC_DIVZ    = 6'd8,
        EXC_INVALID = 6'd16,
        EXC_UNIMPL  = 6'd32
    } exc_code_e;

    typedef struct packed {
        logic                cause_we;
        logic [CAUSE_W-1:0]  cause;
        logic                flag_we;
        logic [MASK_W-1:0]   flags;
        logic                cc_we;
        logic [CC_SEL_W-1:0] cc_sel;
        logic                cc_val;
    } au_req_t;

    function automatic logic mask_hit(input logic [CAUSE_W-1:0] cause,
                                      input logic [MASK_W-1:0]  enable);
        return (|(cause[MASK_W-1:0] & enable)) | cause[CAUSE_W-1];
    endfunction
endpackage

// File: rtl/fcsr_cc_unit.sv
module fcsr_cc_unit
    import fcsr_pkg::*;
(
    input  logic [CC_COUNT-1:0] cc_cur,
    input  logic                cc_we,
    input  logic [CC_SEL_W-1:0] cc_sel,
    input  logic                cc_val,
    output logic [CC_COUNT-1:0] cc_next
);
    for (genvar i = 0; i < CC_COUNT; i++) begin : g_code
        always_comb begin
            if (cc_we && (cc_sel == CC_SEL_W'(i)))
                cc_next[i] = cc_val;
            else
                cc_next[i] = cc_cur[i];
        end
    end
endmodule

// File: rtl/fcsr_exc_unit.sv
module fcsr_exc_unit
    import fcsr_pkg::*;
(
    input  logic [CAUSE_W-1:0] cause_cur,
    input  logic [MASK_W-1:0]  enable_cur,
    input  logic [MASK_W-1:0]  flags_cur,
    input  logic               cause_we,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic               flag_we,
    input  logic [MASK_W-1:0]  flags_in,
    output logic [CAUSE_W-1:0] cause_next,
    output logic [MASK_W-1:0]  flags_next,
    output logic               trap
);
    always_comb begin
        cause_next = cause_we ? cause_in : cause_cur;
        flags_next = flags_cur | (flag_we ? flags_in : '0);
        trap       = mask_hit(cause_cur, enable_cur);
    end
endmodule

// File: rtl/fcsr_reg.sv
module fcsr_reg
    import fcsr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sw_we,
    input  logic [WORD_W-1:0]   sw_wdata,
    output logic [WORD_W-1:0]   sw_rdata,
    input  logic                au_cause_we,
    input  logic [CAUSE_W-1:0]  au_cause,
    input  logic                au_flag_we,
    input  logic [MASK_W-1:0]   au_flags,
    input  logic                au_cc_we,
    input  logic [CC_SEL_W-1:0] au_cc_sel,
    input  logic                au_cc_val,
    output logic [CC_COUNT-1:0] cc_byte,
    output logic                trap
);
    logic [WORD_W-1:0]   csr_q, csr_d;
    logic [CC_COUNT-1:0] cc_cur, cc_next;
    logic [CAUSE_W-1:0]  cause_next;
    logic [MASK_W-1:0]   flags_next;
    au_req_t             req;

    assign req = '{cause_we: au_cause_we, cause: au_cause,
                   flag_we: au_flag_we, flags: au_flags,
                   cc_we: au_cc_we, cc_sel: au_cc_sel, cc_val: au_cc_val};

    assign cc_cur = {csr_q[CCHI_MSB:CCHI_LSB], csr_q[CC0_POS]};

    fcsr_cc_unit u_cc (
        .cc_cur (cc_cur),
        .cc_we  (req.cc_we),
        .cc_sel (req.cc_sel),
        .cc_val (req.cc_val),
        .cc_next(cc_next)
    );

    fcsr_exc_unit u_exc (
        .cause_cur (csr_q[CAUSE_MSB:CAUSE_LSB]),
        .enable_cur(csr_q[EN_MSB:EN_LSB]),
        .flags_cur (csr_q[FLAG_MSB:FLAG_LSB]),
        .cause_we  (req.cause_we),
        .cause_in  (req.cause),
        .flag_we   (req.flag_we),
        .flags_in  (req.flags),
        .cause_next(cause_next),
        .flags_next(flags_next),
        .trap      (trap)
    );

    always_comb begin
        if (sw_we) begin
            csr_d = sw_wdata;
        end else begin
            csr_d                      = csr_q;
            csr_d[CAUSE_MSB:CAUSE_LSB] = cause_next;
            csr_d[FLAG_MSB:FLAG_LSB]   = flags_next;
            csr_d[CCHI_MSB:CCHI_LSB]   = cc_next[CC_COUNT-1:1];
            csr_d[CC0_POS]             = cc_next[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) csr_q <= '0;
        else     csr_q <= csr_d;
    end

    assign sw_rdata = csr_q;
    assign cc_byte  = cc_cur;

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R8: a software write always lands intact
    assert_sw_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && sw_we) |=> (sw_rdata == $past(sw_wdata)));

    // R4: flags only accumulate unless software rewrites the word
    assert_flags_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !sw_we) |=>
        ((sw_rdata[FLAG_MSB:FLAG_LSB] & $past(sw_rdata[FLAG_MSB:FLAG_LSB]))
            == $past(sw_rdata[FLAG_MSB:FLAG_LSB])));

    // R3: cause field holds without an update
    assert_cause_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !sw_we && !au_cause_we) |=>
        $stable(sw_rdata[CAUSE_MSB:CAUSE_LSB]));

    // R5: a lone condition-code update flips at most one bit
    assert_cc_single_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !sw_we && !au_cause_we && !au_flag_we) |=>
        ($countones(sw_rdata ^ $past(sw_rdata)) <= 1));

    // R7: unimplemented cause cannot be masked
    assert_unimpl_trap_R7: assert property (@(posedge clk) disable iff (rst)
        sw_rdata[CAUSE_MSB] |-> trap);
endmodule

// File: tb/sim_fcsr_reg.sv
`timescale 1ns/1ps
module sim_fcsr_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_we = 1'b0;
    logic [31:0] sw_wdata = '0;
    logic [31:0] sw_rdata;
    logic        au_cause_we = 1'b0;
    logic [5:0]  au_cause = '0;
    logic        au_flag_we = 1'b0;
    logic [4:0]  au_flags = '0;
    logic        au_cc_we = 1'b0;
    logic [2:0]  au_cc_sel = '0;
    logic        au_cc_val = 1'b0;
    logic [7:0]  cc_byte;
    logic        trap;

    always #2 clk = ~clk;

    fcsr_reg u0 (.*);

    typedef struct {
        logic [31:0] word;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mdl = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 0;

    function automatic logic [7:0] exp_cc(input logic [31:0] w);
        return {w[31:25], w[23]};
    endfunction

    function automatic logic exp_trap(input logic [31:0] w);
        return (|(w[16:12] & w[11:7])) | w[17];
    endfunction

    task automatic compare(input string tag, input logic [31:0] w);
        n_chk++;
        if (sw_rdata !== w || cc_byte !== exp_cc(w) || trap !== exp_trap(w)) begin
            n_fail++;
            $display("FAIL %s: word=%h cc=%h trap=%b expected word=%h cc=%h trap=%b",
                     tag, sw_rdata, cc_byte, trap, w, exp_cc(w), exp_trap(w));
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected word
    task automatic step(input string tag,
                        input logic swe, input logic [31:0] wd,
                        input logic cwe, input logic [5:0] c,
                        input logic fwe, input logic [4:0] f,
                        input logic ccwe, input logic [2:0] s, input logic v);
        exp_t e;
        @(negedge clk);
        sw_we = swe; sw_wdata = wd;
        au_cause_we = cwe; au_cause = c;
        au_flag_we = fwe; au_flags = f;
        au_cc_we = ccwe; au_cc_sel = s; au_cc_val = v;
        @(posedge clk);
        if (swe) begin
            mdl = wd;
        end else begin
            if (cwe)  mdl[17:12] = c;
            if (fwe)  mdl[6:2]   = mdl[6:2] | f;
            if (ccwe) begin
                if (s == 3'd0) mdl[23] = v;
                else           mdl[32'(s) + 24] = v;
            end
        end
        #1;
        e.word = mdl; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            compare(e.tag, e.word);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1 reset", 32'h0);
        rst = 1'b0;
        step("R1 idle after reset", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2 full word write
        step("R2 write pattern", 1, 32'hA5C3_0F96, 0, 0, 0, 0, 0, 0, 0);
        step("R2 write other", 1, 32'h5A3C_E069, 0, 0, 0, 0, 0, 0, 0);
        step("R2 write zero", 1, 32'h0, 0, 0, 0, 0, 0, 0, 0);
        // R3 cause replace
        step("R3 cause write", 0, 0, 1, 6'h15, 0, 0, 0, 0, 0);
        step("R3 cause replace", 0, 0, 1, 6'h02, 0, 0, 0, 0, 0);
        step("R3 cause hold", 0, 0, 0, 6'h3F, 0, 0, 0, 0, 0);
        // R4 sticky flags
        step("R4 flag inexact", 0, 0, 0, 0, 1, 5'h01, 0, 0, 0);
        step("R4 flag invalid", 0, 0, 0, 0, 1, 5'h10, 0, 0, 0);
        step("R4 flag zero merge", 0, 0, 0, 0, 1, 5'h00, 0, 0, 0);
        // R5 / R6 condition codes
        step("R5 R6 set code0", 0, 0, 0, 0, 0, 0, 1, 3'd0, 1);
        step("R5 R6 set code7", 0, 0, 0, 0, 0, 0, 1, 3'd7, 1);
        step("R5 R6 set code3", 0, 0, 0, 0, 0, 0, 1, 3'd3, 1);
        step("R5 R6 set code1", 0, 0, 0, 0, 0, 0, 1, 3'd1, 1);
        step("R5 clear code0", 0, 0, 0, 0, 0, 0, 1, 3'd0, 0);
        step("R5 clear code7", 0, 0, 0, 0, 0, 0, 1, 3'd7, 0);
        // R7 trap
        step("R7 enable overflow", 1, 32'h0000_0200, 0, 0, 0, 0, 0, 0, 0);
        step("R7 cause overflow traps", 0, 0, 1, 6'h04, 0, 0, 0, 0, 0);
        step("R7 cause inexact masked", 0, 0, 1, 6'h01, 0, 0, 0, 0, 0);
        step("R7 cause unimpl traps", 0, 0, 1, 6'h20, 0, 0, 0, 0, 0);
        step("R7 all enabled", 1, 32'h0000_0F80, 0, 0, 0, 0, 0, 0, 0);
        step("R7 cause invalid traps", 0, 0, 1, 6'h10, 0, 0, 0, 0, 0);
        step("R7 cause cleared", 0, 0, 1, 6'h00, 0, 0, 0, 0, 0);
        // R8 software priority
        step("R8 collide", 1, 32'h1234_5678, 1, 6'h3F, 1, 5'h1F, 1, 3'd2, 1);
        step("R8 collide zero", 1, 32'h0, 1, 6'h2A, 1, 5'h15, 1, 3'd0, 1);
        // R9 simultaneous arithmetic updates
        step("R9 all three", 0, 0, 1, 6'h08, 1, 5'h08, 1, 3'd5, 1);
        step("R9 all three again", 0, 0, 1, 6'h11, 1, 5'h03, 1, 3'd0, 1);
        step("R9 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule